// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read side of a NOR-style memory port. A read begins on any clock edge where chip enable (`ce_n`) and the address strobe (`adv_n`) are both low. At that edge the start address and the read target are captured. The sequencer waits a programmable first-access latency and then presents 16-bit words on `dout`, qualified by `dvalid`. Data comes from an internal computed lookup with a registered output. While a synchronous burst has no valid data, the block raises `rd_wait`.

A 16-bit read configuration word selects the behaviour:

- The read mode: synchronous burst, or a page mode that ignores every other field.
- The latency.
- The burst length, and whether addresses wrap.
- A one- or two-clock hold per word.
- Whether the wait flag leads the delay it marks.

One combination of latency, hold and early wait is unsupported. Reserved bits and reserved codes are also rejected. Both cases raise a flag, and array reads then fall back to single words. Status and configuration reads always return exactly one word.

Top module: `brs_burst_rd`

## Requirements
- R1: After reset, `dvalid`, `rd_wait`, `dout`, `err_rsvd` and `err_combo` are all 0. The configuration word reads back as 16'h980F: page mode, latency code 3, no wrap, continuous length.
- R2: Call the start edge cycle 0. In burst mode (bit 15 = 0), the latency code in bits 13:11 (2 to 5) gives L. The first word is valid after clock edge L, and `dvalid` stays low after the start edge itself.
- R3: With bit 9 = 1, each word stays valid for 2 consecutive cycles. With bit 9 = 0, each word is valid for 1 cycle.
- R4: With bit 3 = 0 and length code 001, 010 or 011 in bits 2:0 (4, 8 or 16 words), the addresses wrap inside the aligned window of that size. The burst ends after exactly that many words.
- R5: With bit 3 = 1, or with length code 111 (continuous), the address increments by one per word without end. It rolls over from the top of the address space to 0. It stops only when a new start or `ce_n` high ends it.
- R6: In continuous mode, when the next address has its low four bits equal to 0, one cycle with no valid data is inserted before that word.
- R7: During a burst, with bit 8 = 0, `rd_wait` is 1 exactly in the latency cycles after edges 1 to L-1 and in inserted gap cycles. With bit 8 = 1, the same pattern appears one clock earlier.
- R8: Writing latency code 2 together with bit 9 = 1 and bit 8 = 1 sets `err_combo`. While it is set, array reads in burst mode return one word after 2 clocks with no wait.
- R9: Several writes set `err_rsvd`: any of bits 14, 10 or 7:4 set, a latency code outside 2..5, or a length code other than 001, 010, 011 or 111. The stored word has bits 14, 10 and 7:4 cleared. While the flag is set, array reads in burst mode are single-word. The flags change only on a configuration write, and a clean write clears them.
- R10: In page mode (bit 15 = 1), an array read returns 4 words, one per clock, starting after edge 2. The addresses wrap inside the aligned 4-word page, and `rd_wait` stays 0.
- R11: A read with `rd_sel` = 1 returns the status word {14'b0, err_rsvd, err_combo}. A read with `rd_sel` = 2 or 3 returns the stored configuration. Each is a single word after edge 2 with no wait, whatever the burst settings.
- R12: An array word at address a is {e[7:0], e[15:8]} ^ 16'h5AC3, where e is a zero-extended to 16 bits. `dout` is 0 whenever `dvalid` is 0.
- R13: After any edge where `ce_n` is high, `dvalid` and `rd_wait` are 0 and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| ce_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address strobe; low with `ce_n` low starts a read |
| addr | input | AW | Start address |
| rd_sel | input | 2 | Read target: 0 array, 1 status, 2 or 3 configuration |
| dout | output | 16 | Read data, 0 when not valid |
| dvalid | output | 1 | Data on `dout` is valid |
| rd_wait | output | 1 | Burst data delayed (or about to be, in early mode) |
| err_rsvd | output | 1 | Last write had a reserved bit or reserved code |
| err_combo | output | 1 | Last write selected the unsupported latency/hold/early mix |

## Verification
The bench builds the block with `AW` = 10 instead of the default 16. This makes a 1024-word address space, so a continuous burst started near 10'h3FD rolls over to address 0 within a few words. The same burst also meets the 16-word boundary gap. Random legal configurations cover every latency, hold, early-wait, wrap and length value against arbitrary 10-bit start addresses. Directed writes drive the forbidden mix and each kind of reserved setting, so the fallback single-word reads can be checked.

// File: rtl/brs_pkg.sv
package brs_pkg;
    localparam int unsigned DW = 16;
    localparam logic [DW-1:0] CFG_RESET = 16'h980F;
    localparam logic [DW-1:0] CFG_RSVD  = 16'h44F0;
    localparam int unsigned MAX_BURST = 16;
    localparam int unsigned LEFT_W = $clog2(MAX_BURST) + 1;
    localparam logic [1:0] SEL_ARRAY  = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;

    typedef enum logic [1:0] {PH_IDLE, PH_LAT, PH_DATA, PH_GAP} phase_e;

    typedef struct packed {
        logic [DW-1:0] word;
        logic          rsvd;
        logic          combo;
    } cfg_st_t;
endpackage

// File: rtl/brs_cfg.sv
module brs_cfg
    import brs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_word,
    output logic          err_rsvd,
    output logic          err_combo,
    output logic          burst_ok,
    output logic          page_mode,
    output logic [1:0]    lat_m2,
    output logic          hold2,
    output logic          early,
    output logic          wrap_en,
    output logic          endless,
    output logic          gap_en,
    output logic [3:0]    wmask
);
    cfg_st_t st_d, st_q;
    logic [2:0] w_lat, w_len, lat, len;
    logic       w_lat_ok, w_len_ok, cont;

    always_comb begin
        w_lat    = wdata[13:11];
        w_len    = wdata[2:0];
        w_lat_ok = (w_lat >= 3'd2) && (w_lat <= 3'd5);
        w_len_ok = (w_len == 3'd1) || (w_len == 3'd2) || (w_len == 3'd3) || (w_len == 3'd7);
        st_d = st_q;
        if (we) begin
            st_d.word  = wdata & ~CFG_RSVD;
            st_d.rsvd  = (|(wdata & CFG_RSVD)) || !w_lat_ok || !w_len_ok;
            st_d.combo = (w_lat == 3'd2) && wdata[9] && wdata[8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{word: CFG_RESET, rsvd: 1'b0, combo: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        lat       = st_q.word[13:11];
        len       = st_q.word[2:0];
        cont      = (len == 3'd7);
        cfg_word  = st_q.word;
        err_rsvd  = st_q.rsvd;
        err_combo = st_q.combo;
        page_mode = st_q.word[15];
        burst_ok  = !st_q.word[15] && !st_q.rsvd && !st_q.combo;
        lat_m2    = 2'(lat - 3'd2);
        hold2     = st_q.word[9];
        early     = st_q.word[8];
        wrap_en   = !st_q.word[3] && !cont;
        endless   = !wrap_en;
        gap_en    = cont;
        unique case (len)
            3'd1:    wmask = 4'h3;
            3'd2:    wmask = 4'h7;
            default: wmask = 4'hF;
        endcase
    end
endmodule

// File: rtl/brs_next_addr.sv
module brs_next_addr #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [3:0]    wmask,
    input  logic          wrap_en,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] mask_w, inc;

    always_comb begin
        mask_w = AW'(wmask);
        inc    = cur + AW'(1);
        nxt    = wrap_en ? ((cur & ~mask_w) | (inc & mask_w)) : inc;
    end
endmodule

// File: rtl/brs_lookup.sv
module brs_lookup #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] addr,
    output logic [15:0]   word
);
    logic [15:0] ext;

    if (AW >= 16) begin : g_trim
        assign ext = addr[15:0];
    end else begin : g_pad
        assign ext = {{(16-AW){1'b0}}, addr};
    end

    assign word = {ext[7:0], ext[15:8]} ^ 16'h5AC3;
endmodule

// File: rtl/brs_burst_rd.sv
module brs_burst_rd
    import brs_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_wdata,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    rd_sel,
    output logic [15:0]   dout,
    output logic          dvalid,
    output logic          rd_wait,
    output logic          err_rsvd,
    output logic          err_combo
);
    typedef struct packed {
        phase_e            phase;
        logic [1:0]        cnt;
        logic              hold;
        logic [AW-1:0]     addr;
        logic [LEFT_W-1:0] left;
        logic              endless;
        logic              gap_en;
        logic              wrap_en;
        logic              hold2;
        logic              early;
        logic              waiten;
        logic [3:0]        wmask;
        logic [1:0]        sel;
        logic              dv;
        logic              wt;
        logic [DW-1:0]     data;
    } st_t;

    st_t st_d, st_q;

    logic [DW-1:0] cfg_word, arr_word, word_mux;
    logic          burst_ok, page_mode, hold2, early, wrap_en, endless, gap_en;
    logic [1:0]    lat_m2;
    logic [3:0]    wmask;
    logic [AW-1:0] nxt_addr;
    logic          start, cur_valid, early_term, late_term;

    brs_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg_word(cfg_word), .err_rsvd(err_rsvd), .err_combo(err_combo),
        .burst_ok(burst_ok), .page_mode(page_mode), .lat_m2(lat_m2),
        .hold2(hold2), .early(early), .wrap_en(wrap_en), .endless(endless),
        .gap_en(gap_en), .wmask(wmask)
    );

    brs_next_addr #(.AW(AW)) u_step (
        .cur(st_q.addr), .wmask(st_q.wmask), .wrap_en(st_q.wrap_en), .nxt(nxt_addr)
    );

    brs_lookup #(.AW(AW)) u_lut (
        .addr(st_q.addr), .word(arr_word)
    );

    always_comb begin
        st_d      = st_q;
        start     = !ce_n && !adv_n;
        cur_valid = (st_q.phase == PH_DATA);

        unique case (st_q.sel)
            SEL_ARRAY:  word_mux = arr_word;
            SEL_STATUS: word_mux = {14'd0, err_rsvd, err_combo};
            default:    word_mux = cfg_word;
        endcase

        if (ce_n) begin
            st_d.phase = PH_IDLE;
        end else if (start) begin
            st_d.phase = PH_LAT;
            st_d.addr  = addr;
            st_d.hold  = 1'b0;
            st_d.sel   = rd_sel;
            if (rd_sel == SEL_ARRAY && burst_ok) begin
                st_d.cnt = lat_m2;  st_d.hold2 = hold2;  st_d.early = early;
                st_d.waiten = 1'b1; st_d.wrap_en = wrap_en; st_d.endless = endless;
                st_d.gap_en = gap_en; st_d.wmask = wmask;
            end else if (rd_sel == SEL_ARRAY && page_mode) begin
                st_d.cnt = 2'd0;    st_d.hold2 = 1'b0;  st_d.early = 1'b0;
                st_d.waiten = 1'b0; st_d.wrap_en = 1'b1; st_d.endless = 1'b0;
                st_d.gap_en = 1'b0; st_d.wmask = 4'h3;
            end else begin
                st_d.cnt = 2'd0;    st_d.hold2 = 1'b0;  st_d.early = 1'b0;
                st_d.waiten = 1'b0; st_d.wrap_en = 1'b0; st_d.endless = 1'b0;
                st_d.gap_en = 1'b0; st_d.wmask = 4'h0;
            end
            st_d.left = LEFT_W'(st_d.wmask) + LEFT_W'(1);
        end else begin
            unique case (st_q.phase)
                PH_LAT: begin
                    if (st_q.cnt == 2'd0) st_d.phase = PH_DATA;
                    else                  st_d.cnt   = st_q.cnt - 2'd1;
                end
                PH_DATA: begin
                    if (st_q.hold2 && !st_q.hold) begin
                        st_d.hold = 1'b1;
                    end else begin
                        st_d.hold = 1'b0;
                        if (!st_q.endless && st_q.left == LEFT_W'(1)) begin
                            st_d.phase = PH_IDLE;
                        end else begin
                            if (!st_q.endless) st_d.left = st_q.left - LEFT_W'(1);
                            st_d.addr = nxt_addr;
                            if (st_q.gap_en && nxt_addr[3:0] == 4'd0) st_d.phase = PH_GAP;
                        end
                    end
                end
                PH_GAP:  st_d.phase = PH_DATA;
                default: st_d.phase = PH_IDLE;
            endcase
        end

        st_d.dv    = cur_valid && !ce_n && adv_n;
        st_d.data  = st_d.dv ? word_mux : '0;
        early_term = st_d.waiten && st_d.early &&
                     (st_d.phase == PH_LAT || st_d.phase == PH_GAP);
        late_term  = adv_n && st_q.waiten && !st_q.early &&
                     (st_q.phase == PH_LAT || st_q.phase == PH_GAP);
        st_d.wt    = !ce_n && (early_term || late_term);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.data;
    assign dvalid  = st_q.dv;
    assign rd_wait = st_q.wt;
endmodule

// File: rtl/brs_burst_rd_chk.sv
module brs_burst_rd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic        ce_n,
    input logic        adv_n,
    input logic        dvalid,
    input logic        rd_wait,
    input logic        err_rsvd,
    input logic        err_combo
);
    AST_START_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adv_n) |=> !dvalid); // R2

    AST_LATENCY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !adv_n) ##1 (!ce_n && adv_n) |=> !dvalid); // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dvalid && !rd_wait)); // R13

    AST_COMBO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[13:11] == 3'd2 && cfg_wdata[9] && cfg_wdata[8]) |=> err_combo); // R8

    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (|(cfg_wdata & 16'h44F0))) |=> err_rsvd); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(err_rsvd) && $stable(err_combo))); // R9
endmodule

bind brs_burst_rd brs_burst_rd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ce_n(ce_n), .adv_n(adv_n), .dvalid(dvalid), .rd_wait(rd_wait),
    .err_rsvd(err_rsvd), .err_combo(err_combo)
);

// File: tb/brs_burst_rd_test.sv
module brs_burst_rd_test;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    rd_sel = '0;
    logic [15:0]   dout;
    logic          dvalid, rd_wait, err_rsvd, err_combo;

    always #5 clk = ~clk;

    brs_burst_rd #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ce_n(ce_n), .adv_n(adv_n), .addr(addr), .rd_sel(rd_sel),
        .dout(dout), .dvalid(dvalid), .rd_wait(rd_wait),
        .err_rsvd(err_rsvd), .err_combo(err_combo)
    );

    int checks = 0;
    int failures = 0;
    logic [15:0] m_cfg = 16'h980F;
    bit m_rsvd = 1'b0;
    bit m_combo = 1'b0;
    logic [17:0] exp_t [0:63];
    bit wn [0:64];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] mkcfg(input int lat, input bit hold, input bit erly,
                                          input bit nowrap, input logic [2:0] bl);
        logic [2:0] l3;
        l3 = 3'(lat);
        return {2'b00, l3, 1'b0, hold, erly, 4'b0000, nowrap, bl};
    endfunction

    function automatic logic [15:0] word_of(input logic [1:0] sel, input logic [AW-1:0] a);
        logic [15:0] e;
        e = 16'(a);
        if (sel == 2'd0) return {e[7:0], e[15:8]} ^ 16'h5AC3;
        if (sel == 2'd1) return {14'd0, m_rsvd, m_combo};
        return m_cfg;
    endfunction

    task automatic wr_cfg(input logic [15:0] w);
        logic [2:0] l, b;
        l = w[13:11];
        b = w[2:0];
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_cfg = w & ~16'h44F0;
        m_rsvd = (|(w & 16'h44F0)) || (l < 3'd2) || (l > 3'd5) ||
                 !((b == 3'd1) || (b == 3'd2) || (b == 3'd3) || (b == 3'd7));
        m_combo = (l == 3'd2) && w[9] && w[8];
        check(err_rsvd == m_rsvd && err_combo == m_combo, "R8 R9 flags",
              {30'd0, err_rsvd, err_combo}, {30'd0, m_rsvd, m_combo});
    endtask

    task automatic build(input logic [1:0] sel, input logic [AW-1:0] a0, input int k_len);
        int L, H, words, t, i;
        bit cont, wr, endless, waiten, erly;
        logic [3:0] m;
        logic [AW-1:0] a;
        for (int k = 0; k < 64; k++) exp_t[k] = '0;
        for (int k = 0; k < 65; k++) wn[k] = 1'b0;
        if (sel == 2'd0 && !m_cfg[15] && !m_rsvd && !m_combo) begin
            L = int'(m_cfg[13:11]);
            H = m_cfg[9] ? 2 : 1;
            erly = m_cfg[8];
            cont = (m_cfg[2:0] == 3'd7);
            m = (m_cfg[2:0] == 3'd1) ? 4'h3 : (m_cfg[2:0] == 3'd2) ? 4'h7 : 4'hF;
            wr = !m_cfg[3] && !cont;
            endless = !wr;
            words = int'(m) + 1;
            waiten = 1'b1;
        end else begin
            L = 2; H = 1; erly = 1'b0; cont = 1'b0; waiten = 1'b0; endless = 1'b0;
            if (sel == 2'd0 && m_cfg[15]) begin
                m = 4'h3; wr = 1'b1; words = 4;
            end else begin
                m = 4'h0; wr = 1'b0; words = 1;
            end
        end
        for (int k = 1; k < L; k++) wn[k] = waiten;
        t = L;
        a = a0;
        i = 0;
        while (t < k_len && (endless || i < words)) begin
            if (i > 0) begin
                a = wr ? ((a & ~AW'(m)) | ((a + AW'(1)) & AW'(m))) : (a + AW'(1));
                if (cont && a[3:0] == 4'd0) begin
                    wn[t] = waiten;
                    t++;
                end
            end
            for (int h = 0; h < H; h++) begin
                if (t < k_len) exp_t[t] = {1'b1, 1'b0, word_of(sel, a)};
                t++;
            end
            i++;
        end
        for (int k = 0; k < k_len; k++) exp_t[k][16] = erly ? wn[k+1] : wn[k];
    endtask

    task automatic run_read(input logic [1:0] sel, input logic [AW-1:0] a, input int k_len,
                            input bit abort, input string req);
        logic [17:0] got;
        @(negedge clk);
        ce_n = 1'b0;
        adv_n = 1'b0;
        addr = a;
        rd_sel = sel;
        build(sel, a, k_len);
        @(negedge clk);
        adv_n = 1'b1;
        for (int t = 0; t < k_len; t++) begin
            if (t > 0) @(negedge clk);
            got = {dvalid, rd_wait, dout};
            check(got === exp_t[t], req, 32'(got), 32'(exp_t[t]));
        end
        if (abort) begin
            @(negedge clk);
            ce_n = 1'b1;
            @(negedge clk);
            check(!dvalid && !rd_wait, "R13 abort", {30'd0, dvalid, rd_wait}, 32'd0);
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL timeout actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0] bls [0:3];
        bls[0] = 3'd1; bls[1] = 3'd2; bls[2] = 3'd3; bls[3] = 3'd7;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dvalid && !rd_wait && dout == 16'h0 && !err_rsvd && !err_combo, "R1 reset",
              {13'd0, dvalid, rd_wait, err_rsvd, err_combo, dout}, 32'd0);
        run_read(2'd2, 10'h000, 6, 1'b1, "R1 R11 config read");
        run_read(2'd0, 10'h106, 10, 1'b1, "R10 R12 page");

        for (int lat = 2; lat <= 5; lat++) begin
            wr_cfg(mkcfg(lat, 1'b0, 1'b0, 1'b0, 3'd1));
            run_read(2'd0, 10'h00E, 14, 1'b1, "R2 R4 R7 latency");
        end
        wr_cfg(mkcfg(3, 1'b1, 1'b0, 1'b0, 3'd2));
        run_read(2'd0, 10'h035, 24, 1'b1, "R3 R4 hold2 wrap8");
        wr_cfg(mkcfg(4, 1'b0, 1'b0, 1'b0, 3'd3));
        run_read(2'd0, 10'h1F7, 24, 1'b1, "R4 wrap16");
        wr_cfg(mkcfg(2, 1'b0, 1'b0, 1'b1, 3'd1));
        run_read(2'd0, 10'h3FE, 12, 1'b1, "R5 linear rollover");
        wr_cfg(mkcfg(3, 1'b0, 1'b0, 1'b1, 3'd7));
        run_read(2'd0, 10'h3FD, 16, 1'b1, "R5 R6 R7 continuous");
        run_read(2'd0, 10'h020, 12, 1'b0, "R5 before restart");
        run_read(2'd0, 10'h10E, 16, 1'b1, "R5 restart");
        wr_cfg(mkcfg(4, 1'b0, 1'b1, 1'b1, 3'd7));
        run_read(2'd0, 10'h00C, 20, 1'b1, "R6 R7 early gap");
        wr_cfg(mkcfg(3, 1'b1, 1'b1, 1'b0, 3'd1));
        run_read(2'd0, 10'h005, 16, 1'b1, "R3 R7 early hold2");
        run_read(2'd1, 10'h005, 6, 1'b1, "R11 status clean");

        wr_cfg(mkcfg(2, 1'b1, 1'b1, 1'b0, 3'd1));
        run_read(2'd0, 10'h044, 8, 1'b1, "R8 fallback single");
        run_read(2'd1, 10'h044, 6, 1'b1, "R8 R11 status combo");
        wr_cfg(16'h8000 | mkcfg(2, 1'b1, 1'b1, 1'b0, 3'd1));
        run_read(2'd0, 10'h0A2, 10, 1'b1, "R10 page ignores fields");

        wr_cfg(mkcfg(3, 1'b0, 1'b0, 1'b1, 3'd7) | 16'h0410);
        run_read(2'd3, 10'h000, 6, 1'b1, "R9 R11 masked config");
        run_read(2'd0, 10'h050, 8, 1'b1, "R9 fallback single");
        wr_cfg(mkcfg(7, 1'b0, 1'b0, 1'b1, 3'd7));
        run_read(2'd1, 10'h000, 6, 1'b1, "R9 R11 status rsvd");
        wr_cfg(mkcfg(3, 1'b0, 1'b0, 1'b1, 3'd4));
        wr_cfg(mkcfg(3, 1'b0, 1'b0, 1'b1, 3'd7));
        @(negedge clk);
        check(!err_rsvd && !err_combo, "R9 flags cleared", {30'd0, err_rsvd, err_combo}, 32'd0);

        for (int it = 0; it < 40; it++) begin
            int lat;
            bit hold, erly, nw;
            logic [1:0] sel;
            lat = 2 + int'($urandom % 4);
            hold = 1'($urandom);
            erly = 1'($urandom);
            if (lat == 2 && hold && erly) erly = 1'b0;
            nw = 1'($urandom);
            wr_cfg(mkcfg(lat, hold, erly, nw, bls[$urandom % 4]));
            sel = (($urandom % 8) == 0) ? 2'(1 + ($urandom % 2)) : 2'd0;
            run_read(sel, AW'($urandom), 40, 1'b1, "R2 R3 R4 R5 R6 R7 R12 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule